// File: doc/BRIEF.md
# Sequential-Access Loop Offload Controller

This block replaces a software loop by streaming data through an external single-cycle loop-body datapath. Software first programs a source address, a destination address, an iteration count and a mode. It then writes a start bit and may power the processor down. The controller generates all memory addresses, so no loop counter, exit test or pointer arithmetic remains in the loop body. Each address moves by exactly one location per access, either upward or downward. Read data goes to the datapath, and each result returns to memory. When the last result has been written, the controller raises an interrupt to wake the processor.

Block mode reads one location per cycle for as many cycles as the count gives. The pipeline has three stages: an address cycle, an operand cycle and a write cycle. Once the pipeline is full, one iteration completes every cycle. Single mode performs exactly one read and one write, whatever the count says. The most recent result stays available on a result output that software can read.

Top module: `lpdma_top`

## Requirements
- R1: While idle, a configuration write stores its data in one of four settings, chosen by the select code: 0 source base, 1 destination base, 2 iteration count, 3 mode. In the mode setting, bit0=1 means decrement and bit1=1 means single mode. A write to select 4 with bit0=1 starts a run, and `busy` is high from the clock edge that captures that write.
- R2: In block mode with count N>0, `mem_re` is high for the N consecutive cycles that start right after the start edge. The read addresses run source base, base±1, base±2 and so on, wrapping modulo 2^AW.
- R3: `dp_opnd` shows the read data in the cycle after each read. In the cycle after that, `mem_we` is high, `mem_wdata` equals the `dp_res` of the previous cycle, and `mem_waddr` steps through destination base, base±1 and so on in the same direction as the reads.
- R4: In single mode, exactly one read and one write take place, whatever the programmed count.
- R5: Starting a block run with count 0 makes no memory access and leaves `busy` low. `irq` is high from the start edge onward.
- R6: `busy` falls and `irq` rises on the clock edge that follows the cycle of the last write, which is N+2 edges after the start edge.
- R7: `irq` stays high until a write to select 5 with bit0=1. A new start also clears `irq`, except for a zero-count start.
- R8: While `busy` is high, writes to selects 0 to 4 have no effect. That includes a second start.
- R9: `res_q` holds the last result written to memory until the next one.
- R10: After reset, `busy`, `irq`, `mem_re`, `mem_we` and `res_q` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration select code |
| cfg_wdata | input | CFG_W | Configuration write data |
| mem_re | output | 1 | Memory read request |
| mem_raddr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid one cycle after `mem_re` |
| mem_we | output | 1 | Memory write request |
| mem_waddr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| dp_opnd | output | DW | Operand to the loop-body datapath |
| dp_res | input | DW | Combinational result from the datapath |
| res_q | output | DW | Last result, readable by software |
| busy | output | 1 | A run is in progress |
| irq | output | 1 | Completion interrupt, held until cleared |

## Verification
The checks assume three things about the surroundings:
- The memory returns read data exactly one cycle after a read request.
- The datapath produces its result within the same cycle as its operand.
- Within a run, the source and destination ranges do not overlap, so no read picks up a value that the same run has just written.

The bench models a fixed-latency memory and a purely combinational datapath function. It keeps all read areas apart from all write areas across runs, so every expected value can be computed from the initial memory contents alone.

// File: rtl/lpdma_pkg.sv
package lpdma_pkg;
   typedef enum logic [2:0] {
      SEL_RBASE = 3'd0,
      SEL_WBASE = 3'd1,
      SEL_COUNT = 3'd2,
      SEL_MODE  = 3'd3,
      SEL_GO    = 3'd4,
      SEL_CLR   = 3'd5
   } sel_e;

   typedef struct packed {
      logic single;
      logic dec;
   } mode_t;
endpackage

// File: rtl/lpdma_regs.sv
module lpdma_regs
   import lpdma_pkg::*;
#(
   parameter int AW    = 10,
   parameter int CW    = 16,
   parameter int CFG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             busy,
   output logic [AW-1:0]    rbase,
   output logic [AW-1:0]    wbase,
   output logic [CW-1:0]    count,
   output mode_t            mode,
   output logic             start,
   output logic             clr
);
   logic accept;
   assign accept = cfg_we && !busy;
   assign start  = accept && (cfg_sel == SEL_GO) && cfg_wdata[0];
   assign clr    = cfg_we && (cfg_sel == SEL_CLR) && cfg_wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rbase <= '0;
         wbase <= '0;
         count <= '0;
         mode  <= '0;
      end else if (accept) begin
         case (cfg_sel)
            SEL_RBASE: rbase <= cfg_wdata[AW-1:0];
            SEL_WBASE: wbase <= cfg_wdata[AW-1:0];
            SEL_COUNT: count <= cfg_wdata[CW-1:0];
            SEL_MODE:  mode  <= mode_t'(cfg_wdata[1:0]);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/lpdma_agen.sv
module lpdma_agen #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          dec,
   input  logic          adv,
   output logic [AW-1:0] addr
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         addr <= '0;
      else if (load)
         addr <= base;
      else if (adv)
         addr <= dec ? addr - 1'b1 : addr + 1'b1;
   end
endmodule

// File: rtl/lpdma_pipe.sv
module lpdma_pipe #(
   parameter int CW = 16,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          clr,
   input  logic [CW-1:0] count,
   input  logic          single,
   input  logic [DW-1:0] dp_res,
   output logic          rd_en,
   output logic          wr_en,
   output logic [DW-1:0] result,
   output logic          busy,
   output logic          irq
);
   logic [CW-1:0] left;
   logic          opnd_vld;
   logic          zero_run;

   assign zero_run = !single && (count == '0);
   assign rd_en    = busy && (left != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left     <= '0;
         opnd_vld <= 1'b0;
         wr_en    <= 1'b0;
         result   <= '0;
         busy     <= 1'b0;
         irq      <= 1'b0;
      end else if (start) begin
         left     <= single ? CW'(1) : count;
         opnd_vld <= 1'b0;
         wr_en    <= 1'b0;
         busy     <= !zero_run;
         irq      <= zero_run;
      end else begin
         opnd_vld <= rd_en;
         if (rd_en)
            left <= left - CW'(1);
         wr_en <= opnd_vld;
         if (opnd_vld)
            result <= dp_res;
         if (busy && wr_en && !opnd_vld && (left == '0)) begin
            busy <= 1'b0;
            irq  <= 1'b1;
         end else if (clr) begin
            irq <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/lpdma_top.sv
module lpdma_top
   import lpdma_pkg::*;
#(
   parameter int AW    = 10,
   parameter int DW    = 32,
   parameter int CW    = 16,
   parameter int CFG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic             mem_re,
   output logic [AW-1:0]    mem_raddr,
   input  logic [DW-1:0]    mem_rdata,
   output logic             mem_we,
   output logic [AW-1:0]    mem_waddr,
   output logic [DW-1:0]    mem_wdata,
   output logic [DW-1:0]    dp_opnd,
   input  logic [DW-1:0]    dp_res,
   output logic [DW-1:0]    res_q,
   output logic             busy,
   output logic             irq
);
   localparam int NPORT = 2;

   if (AW < 1 || AW > CFG_W) begin : g_bad_aw
      $error("lpdma_top: AW must lie in 1..CFG_W");
   end
   if (CW < 1 || CW > CFG_W) begin : g_bad_cw
      $error("lpdma_top: CW must lie in 1..CFG_W");
   end
   if (DW < 1) begin : g_bad_dw
      $error("lpdma_top: DW must be positive");
   end

   logic [AW-1:0] rbase_q, wbase_q;
   logic [CW-1:0] count_q;
   mode_t         mode_q;
   logic          start, clr;
   logic          mode_dec;
   logic [DW-1:0] result;

   lpdma_regs #(.AW(AW), .CW(CW), .CFG_W(CFG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .busy(busy), .rbase(rbase_q), .wbase(wbase_q),
      .count(count_q), .mode(mode_q), .start(start), .clr(clr)
   );

   lpdma_pipe #(.CW(CW), .DW(DW)) u_pipe (
      .clk(clk), .rst_n(rst_n), .start(start), .clr(clr), .count(count_q),
      .single(mode_q.single), .dp_res(dp_res), .rd_en(mem_re),
      .wr_en(mem_we), .result(result), .busy(busy), .irq(irq)
   );

   assign mode_dec = mode_q.dec;

   logic [AW-1:0] ag_base [NPORT];
   logic          ag_adv  [NPORT];
   logic [AW-1:0] ag_addr [NPORT];

   assign ag_base[0] = rbase_q;
   assign ag_base[1] = wbase_q;
   assign ag_adv[0]  = mem_re;
   assign ag_adv[1]  = mem_we;

   for (genvar g = 0; g < NPORT; g++) begin : g_agen
      lpdma_agen #(.AW(AW)) u_agen (
         .clk(clk), .rst_n(rst_n), .load(start), .base(ag_base[g]),
         .dec(mode_dec), .adv(ag_adv[g]), .addr(ag_addr[g])
      );
   end

   assign mem_raddr = ag_addr[0];
   assign mem_waddr = ag_addr[1];
   assign dp_opnd   = mem_rdata;
   assign mem_wdata = result;
   assign res_q     = result;
endmodule

// File: rtl/lpdma_chk.sv
module lpdma_chk
   import lpdma_pkg::*;
#(
   parameter int AW = 10,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          irq,
   input logic          mem_re,
   input logic [AW-1:0] mem_raddr,
   input logic          mem_we,
   input logic [DW-1:0] mem_wdata,
   input logic [DW-1:0] dp_res,
   input logic          cfg_we,
   input logic [2:0]    cfg_sel,
   input logic          go_bit,
   input logic          dec,
   input logic [AW-1:0] rbase
);
   // R2
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re && $past(mem_re) |->
         mem_raddr == (dec ? $past(mem_raddr) - 1'b1 : $past(mem_raddr) + 1'b1));

   // R2
   rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> busy);

   // R3
   wr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_wdata == $past(dp_res));

   // R3
   wr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(mem_re, 2));

   // R6
   done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq);

   // R7
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !(cfg_we && cfg_sel == SEL_CLR && go_bit)
          && !(cfg_we && cfg_sel == SEL_GO && go_bit && !busy) |=> irq);

   // R8
   cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(rbase));
endmodule

bind lpdma_top lpdma_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .mem_re(mem_re),
   .mem_raddr(mem_raddr), .mem_we(mem_we), .mem_wdata(mem_wdata),
   .dp_res(dp_res), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
   .go_bit(cfg_wdata[0]), .dec(mode_dec), .rbase(rbase_q)
);

// File: tb/tb_lpdma_top.sv
module tb_lpdma_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam int DW = 32;
   localparam int CW = 16;
   localparam int CFG_W = 16;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [2:0] cfg_sel = '0;
   logic [CFG_W-1:0] cfg_wdata = '0;
   logic mem_re, mem_we, busy, irq;
   logic [AW-1:0] mem_raddr, mem_waddr;
   logic [DW-1:0] mem_rdata, mem_wdata, dp_opnd, dp_res, res_q;

   logic [DW-1:0] mem [DEPTH];

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lpdma_top #(.AW(AW), .DW(DW), .CW(CW), .CFG_W(CFG_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .mem_re(mem_re), .mem_raddr(mem_raddr),
      .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
      .mem_wdata(mem_wdata), .dp_opnd(dp_opnd), .dp_res(dp_res),
      .res_q(res_q), .busy(busy), .irq(irq)
   );

   function automatic logic [DW-1:0] init_val(int a);
      return DW'(a * 13 + 32'h1000);
   endfunction

   function automatic logic [DW-1:0] body(logic [DW-1:0] x);
      return x * 3 + 17;
   endfunction

   function automatic logic [AW-1:0] step(int base, int k, bit dec);
      return dec ? AW'(base - k) : AW'(base + k);
   endfunction

   assign dp_res = body(dp_opnd);

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= init_val(i);
      end else begin
         if (mem_re) mem_rdata <= mem[mem_raddr];
         if (mem_we) mem[mem_waddr] <= mem_wdata;
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         failures++;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<=50000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cfg(int sel, int data);
      cfg_we    = 1'b1;
      cfg_sel   = 3'(sel);
      cfg_wdata = CFG_W'(data);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   // Starts a run and compares every cycle against the timeline of R2, R3, R5, R6.
   task automatic run(int rb, int wb, int n, bit dec, bit single, string tag, bit inject);
      int neff;
      neff = single ? 1 : n;
      cfg(4, 1);
      for (int k = 0; k <= neff + 3; k++) begin
         chk({tag, " R6"}, "busy", 64'(busy), 64'((neff > 0) && (k <= neff + 1)));
         chk({tag, " R6 R7"}, "irq", 64'(irq), 64'((neff == 0) || (k >= neff + 2)));
         chk({tag, " R2"}, "mem_re", 64'(mem_re), 64'(k < neff));
         if (k < neff)
            chk({tag, " R2"}, "raddr", 64'(mem_raddr), 64'(step(rb, k, dec)));
         chk({tag, " R3"}, "mem_we", 64'(mem_we), 64'((k >= 2) && (k <= neff + 1)));
         if (k >= 2 && k <= neff + 1) begin
            chk({tag, " R3"}, "waddr", 64'(mem_waddr), 64'(step(wb, k - 2, dec)));
            chk({tag, " R3"}, "wdata", 64'(mem_wdata),
                64'(body(init_val(int'(step(rb, k - 2, dec))))));
         end
         if (k >= 1 && k <= neff)
            chk({tag, " R3"}, "dp_opnd", 64'(dp_opnd),
                64'(init_val(int'(step(rb, k - 1, dec)))));
         if (inject && k == 1) begin
            cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = CFG_W'(777);
         end else if (inject && k == 2) begin
            cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = CFG_W'(1);
         end else if (inject && k == 3) begin
            cfg_we = 1'b0;
         end
         @(negedge clk);
      end
      for (int i = 0; i < neff; i++)
         chk({tag, " R3"}, "mem", 64'(mem[step(wb, i, dec)]),
             64'(body(init_val(int'(step(rb, i, dec))))));
      if (neff > 0)
         chk({tag, " R9"}, "res_q", 64'(res_q),
             64'(body(init_val(int'(step(rb, neff - 1, dec))))));
   endtask

   task automatic hold_and_clear(string tag);
      for (int i = 0; i < 3; i++) begin
         chk({tag, " R7"}, "irq held", 64'(irq), 64'(1));
         @(negedge clk);
      end
      cfg(5, 1);
      chk({tag, " R7"}, "irq cleared", 64'(irq), 64'(0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "busy", 64'(busy), 64'(0));
      chk("R10", "irq", 64'(irq), 64'(0));
      chk("R10", "mem_re", 64'(mem_re), 64'(0));
      chk("R10", "mem_we", 64'(mem_we), 64'(0));
      chk("R10", "res_q", 64'(res_q), 64'(0));

      // R1 block increment
      cfg(0, 0); cfg(1, 200); cfg(2, 5); cfg(3, 0);
      run(0, 200, 5, 1'b0, 1'b0, "R1 block-inc", 1'b0);
      hold_and_clear("R1 block-inc");

      // R2 decrement with wrap below zero
      cfg(0, 3); cfg(1, 600); cfg(2, 6); cfg(3, 1);
      run(3, 600, 6, 1'b1, 1'b0, "wrap-dec", 1'b0);

      // R4 single mode ignores count; R7 start clears pending irq
      cfg(0, 10); cfg(1, 300); cfg(2, 9); cfg(3, 2);
      run(10, 300, 9, 1'b0, 1'b1, "R4 single", 1'b0);
      hold_and_clear("R4 single");

      // R5 zero count
      cfg(0, 50); cfg(1, 700); cfg(2, 0); cfg(3, 0);
      run(50, 700, 0, 1'b0, 1'b0, "R5 zero", 1'b0);
      hold_and_clear("R5 zero");

      // R8 long run with writes while busy
      cfg(0, 20); cfg(1, 400); cfg(2, 40); cfg(3, 0);
      run(20, 400, 40, 1'b0, 1'b0, "R8 busy-writes", 1'b1);
      chk("R8", "no restart", 64'(busy), 64'(0));
      hold_and_clear("R8 busy-writes");

      // R8 source base kept its old value
      cfg(1, 450); cfg(2, 3);
      run(20, 450, 3, 1'b0, 1'b0, "R8 reuse", 1'b0);
      hold_and_clear("R8 reuse");

      summary();
      $finish;
   end
endmodule